// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked system and one external asynchronous static RAM. It takes single-word read and write requests over a valid/ready handshake and produces the chip-enable, output-enable, write-enable, address and data-bus sequences for each one. The data bus is split at this boundary into an output value, an output-enable and an input value, which the pad ring combines into the shared tri-state bus. Every control and address output comes from a flip-flop, so the enable pins never see a glitch.

All memory timing minima are parameters in nanoseconds. Each one becomes a clock count by dividing by `CLK_NS` and rounding up, with a floor of one cycle. A change of speed grade or clock therefore only needs new parameter values. After reset the controller waits out the supply-settling interval before it accepts any request. After every read it leaves the bus idle long enough for the memory's output drivers to release, and only then can a write drive data.

The request channel applies back-pressure by holding `req_ready` low. A request is taken on the rising clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid`, `req_write`, `req_addr` and `req_wdata` steady until that edge. Only one access is in flight at a time. Read data comes back on `rsp_valid`, a single-cycle pulse that cannot be stalled.

Top module: `sram_seq_ctrl`

Cycle counts used below: ACC = max(ceil(T_AA_NS/CLK_NS), ceil(T_RC_NS/CLK_NS)); PULSE = the largest of the rounded-up T_PWE_NS, T_SD_NS, T_SCE_NS and T_AW_NS; TURN = ceil(T_HZOE_NS/CLK_NS); PWR = ceil(T_PWR_NS/CLK_NS). Each count is at least 1. With the default parameters these are ACC=2, PULSE=1, TURN=1 and PWR=100.

## Requirements
- R1: After reset is released, `req_ready` stays low and `mem_ce_n` stays high for the first PWR+1 rising edges. Requests offered during this time are not taken.
- R2: `req_ready` is high only when the controller is idle. A request is accepted on the edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle that follows.
- R3: A write runs as follows, counted from the edge that accepts it. There is one setup cycle with `mem_ce_n` low, `mem_we_n` high and the data driver on. Then `mem_we_n` is low for PULSE cycles. Then there is one recovery cycle with `mem_we_n` high and `mem_ce_n` still low. `mem_we_n` is never low while `mem_ce_n` is high.
- R4: `mem_addr` and `mem_dq_o` hold the accepted request's values from the setup cycle through the recovery cycle, and they never change while `mem_we_n` is low.
- R5: `mem_oe_n` is high for the whole of a write. `mem_dq_oe` is high only in the three write phases, and never while `mem_oe_n` is low.
- R6: A read holds `mem_ce_n` and `mem_oe_n` low with a stable address for ACC cycles. It samples `mem_dq_i` at the edge that ends those cycles. In the next cycle it raises both enables and gives a single-cycle `rsp_valid` with the sampled word on `rsp_rdata`.
- R7: After each read's response cycle, TURN cycles follow with all enables high and the data driver off. Only after these does `req_ready` return.
- R8: After a write's recovery cycle, `req_ready` returns in the very next cycle with no turnaround. Back-to-back writes can therefore be accepted every PULSE+3 edges.
- R9: While reset is held, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, and `mem_dq_oe`, `req_ready` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | DATA_W | Read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enables the controller's data drivers |
| mem_dq_i | input | DATA_W | Data seen on the memory bus |

## Verification
The memory model in the bench returns the inverse of the stored word until the address has been stable with both enables low for ACC cycles. A controller that samples a read one cycle early therefore returns corrupted data. Requests are offered at once after reset, and a controller with a short power-up count would accept one of them during the lockout. Reads and writes are interleaved in both orders, and two writes are sent back to back. A missing turnaround, a turnaround added after writes, or a write pulse of the wrong length shows up as a miscompare of `req_ready` or `mem_we_n` in the exact cycle. Reads of freshly written addresses catch a write whose data or address moved before `mem_we_n` rose.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_CAP,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_REC,
    ST_TURN
  } seq_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_pwr_lockout.sv
module sram_pwr_lockout #(
  parameter int unsigned WAIT_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int unsigned CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);

  AST_LOCK_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R1

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          last
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // a phase loaded with N ends after N cycles
  assign last = (cnt <= TW'(1));

  AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0)); // R3

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TW        = 4,
  parameter int unsigned ACC_CYC   = 2,
  parameter int unsigned PULSE_CYC = 1,
  parameter int unsigned TURN_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_done,
  input  logic              tmr_last,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  seq_state_e state, nxt;
  logic       accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_PWRUP:    if (pwr_done) nxt = ST_IDLE;
      ST_IDLE: begin
        if (accept) begin
          if (req_write) nxt = ST_WR_SETUP;
          else begin
            nxt      = ST_RD_ACC;
            tmr_load = 1'b1;
            tmr_val  = TW'(ACC_CYC);
          end
        end
      end
      ST_RD_ACC:   if (tmr_last) nxt = ST_RD_CAP;
      ST_RD_CAP: begin
        nxt      = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = TW'(TURN_CYC);
      end
      ST_TURN:     if (tmr_last) nxt = ST_IDLE;
      ST_WR_SETUP: begin
        nxt      = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = TW'(PULSE_CYC);
      end
      ST_WR_PULSE: if (tmr_last) nxt = ST_WR_REC;
      ST_WR_REC:   nxt = ST_IDLE;
      default:     nxt = ST_PWRUP;
    endcase
  end

  // every pin toward the memory is a flop decoded from the next state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_PWRUP;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state     <= nxt;
      mem_ce_n  <= !(nxt inside {ST_RD_ACC, ST_WR_SETUP, ST_WR_PULSE, ST_WR_REC});
      mem_oe_n  <= (nxt != ST_RD_ACC);
      mem_we_n  <= (nxt != ST_WR_PULSE);
      mem_dq_oe <= (nxt inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_REC});
      if (accept) begin
        mem_addr <= req_addr;
        if (req_write) mem_dq_o <= req_wdata;
      end
      rsp_valid <= (state == ST_RD_ACC) && tmr_last;
      if ((state == ST_RD_ACC) && tmr_last) rsp_rdata <= mem_dq_i;
    end
  end

  AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TURN) |-> (mem_oe_n && mem_ce_n && !mem_dq_oe)); // R7
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R2
  AST_READ_ENABLES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACC) |-> (!mem_ce_n && !mem_oe_n && !mem_dq_oe)); // R6

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_PWR_NS  = 1000,
  parameter int unsigned T_RC_NS   = 12,
  parameter int unsigned T_AA_NS   = 12,
  parameter int unsigned T_PWE_NS  = 8,
  parameter int unsigned T_SCE_NS  = 8,
  parameter int unsigned T_AW_NS   = 8,
  parameter int unsigned T_SD_NS   = 6,
  parameter int unsigned T_HZOE_NS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned PWR_CYC   = ns_to_cyc(T_PWR_NS, CLK_NS);
  localparam int unsigned ACC_CYC   = max_u(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int unsigned PULSE_CYC = max_u(max_u(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                                            max_u(ns_to_cyc(T_SCE_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)));
  localparam int unsigned TURN_CYC  = ns_to_cyc(T_HZOE_NS, CLK_NS);
  localparam int unsigned MAX_CYC   = max_u(max_u(ACC_CYC, PULSE_CYC), TURN_CYC);
  localparam int unsigned TW        = $clog2(MAX_CYC + 1) + 1;

  logic          pwr_done;
  logic          tmr_load;
  logic          tmr_last;
  logic [TW-1:0] tmr_val;

  sram_pwr_lockout #(.WAIT_CYC(PWR_CYC)) u_lockout (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (pwr_done)
  );

  sram_phase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sram_seq_fsm #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .TW        (TW),
    .ACC_CYC   (ACC_CYC),
    .PULSE_CYC (PULSE_CYC),
    .TURN_CYC  (TURN_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_done  (pwr_done),
    .tmr_last  (tmr_last),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_i  (mem_dq_i)
  );

  AST_LOCKOUT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_done |-> (!req_ready && mem_ce_n)); // R1
  AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe)); // R2
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R3
  AST_ADDR_STILL_UNDER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o))); // R4
  AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe)); // R5
  AST_NO_DRIVE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R5
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_RSP_ENABLES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_ce_n && mem_oe_n)); // R6

endmodule

// File: tb/test_sram_seq_ctrl.sv
module test_sram_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 8;
  // cycle counts from the requirements: ceil(ns / 10), at least one
  localparam int ACC   = 2;    // max(12,12) ns
  localparam int PULSE = 1;    // max(8,6,8,8) ns
  localparam int TURN  = 1;    // 6 ns
  localparam int PWR   = 100;  // 1000 ns

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  sram_seq_ctrl i_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int vectors = 0;
  int fails   = 0;
  bit done_flag = 0;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // ---------------- asynchronous memory model ----------------
  logic [DW-1:0] sram   [256];
  logic [DW-1:0] shadow [256];
  int            stab = 0;
  logic [AW-1:0] prev_a = '0;
  logic          prev_we = 1'b1;

  initial begin
    for (int i = 0; i < 256; i++) begin
      sram[i]   = DW'(i * 7 + 3);
      shadow[i] = DW'(i * 7 + 3);
    end
    mem_dq_i = '0;
  end

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_oe_n)
      stab = (mem_addr == prev_a && stab > 0) ? stab + 1 : 1;
    else
      stab = 0;
    prev_a = mem_addr;
    // data is only valid once the access time has elapsed
    mem_dq_i = (stab >= ACC) ? sram[mem_addr[7:0]] : ~sram[mem_addr[7:0]];
    if (!prev_we && mem_we_n && !mem_ce_n) sram[mem_addr[7:0]] = mem_dq_o;
    prev_we = mem_we_n;
  end

  // ---------------- behavioural reference ----------------
  int            since = 0;
  int            busy  = 0;
  bit            m_wr  = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;
  logic [DW-1:0] m_rd   = '0;

  function automatic int last_rel(input bit wr);
    return wr ? PULSE + 2 : ACC + 1 + TURN;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      since = 0;
      busy  = 0;
    end else begin
      bit rdy_pre;
      rdy_pre = (since >= PWR + 1) && (busy == 0);
      if (since < 1000000) since++;
      if (busy > 0) begin
        busy++;
        if (busy > last_rel(m_wr)) busy = 0;
      end
      if (rdy_pre && req_valid) begin
        busy   = 1;
        m_wr   = req_write;
        m_addr = req_addr;
        m_data = req_wdata;
        if (req_write) shadow[req_addr[7:0]] = req_wdata;
        else           m_rd = shadow[req_addr[7:0]];
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && since > 0 && !done_flag) begin
      bit e_rdy, e_ce, e_oe, e_we, e_oe_drv, e_rsp;
      string rtag;
      e_rdy    = (since >= PWR + 1) && (busy == 0);
      e_ce     = (busy > 0) && (m_wr || busy <= ACC);
      e_oe     = (busy > 0) && !m_wr && busy <= ACC;
      e_we     = m_wr && busy >= 2 && busy <= PULSE + 1;
      e_oe_drv = m_wr && busy > 0;
      e_rsp    = !m_wr && busy == ACC + 1;
      if (since < PWR + 1)                  rtag = "R1 ready in lockout";
      else if (!m_wr && busy > ACC + 1)     rtag = "R7 ready in turnaround";
      else if (m_wr && busy == 0)           rtag = "R8 ready after write";
      else                                  rtag = "R2 ready";
      chk(rtag, 32'(req_ready), 32'(e_rdy));
      chk(m_wr ? "R3 mem_ce_n" : (since < PWR + 1 ? "R1 mem_ce_n" : "R6 mem_ce_n"),
          32'(mem_ce_n), 32'(!e_ce));
      chk(m_wr ? "R5 mem_oe_n in write" : "R6 mem_oe_n", 32'(mem_oe_n), 32'(!e_oe));
      chk("R3 mem_we_n", 32'(mem_we_n), 32'(!e_we));
      chk("R5 mem_dq_oe", 32'(mem_dq_oe), 32'(e_oe_drv));
      chk("R6 rsp_valid", 32'(rsp_valid), 32'(e_rsp));
      if (e_ce)     chk("R4 mem_addr", 32'(mem_addr), 32'(m_addr));
      if (e_oe_drv) chk("R4 mem_dq_o", 32'(mem_dq_o), 32'(m_data));
      if (e_rsp)    chk("R6 rsp_rdata", 32'(rsp_rdata), 32'(m_rd));
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input bit wr, input int a, input int d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'(a);
    req_wdata = DW'(d);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset values
    chk("R9 mem_ce_n", 32'(mem_ce_n), 32'd1);
    chk("R9 mem_oe_n", 32'(mem_oe_n), 32'd1);
    chk("R9 mem_we_n", 32'(mem_we_n), 32'd1);
    chk("R9 mem_dq_oe", 32'(mem_dq_oe), 32'd0);
    chk("R9 req_ready", 32'(req_ready), 32'd0);
    chk("R9 rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    // offered during the lockout: must wait (R1)
    send(1'b0, 5, 0);
    send(1'b1, 10, 8'h3C);
    send(1'b0, 10, 0);
    send(1'b1, 11, 8'h5A);           // R8 back-to-back writes
    send(1'b1, 12, 8'hA5);
    send(1'b0, 11, 0);
    send(1'b0, 12, 0);               // R7 read after read
    send(1'b1, 10, 8'hC3);           // write right after read turnaround
    send(1'b0, 10, 0);
    for (int k = 0; k < 6; k++) begin
      send(1'b1, 40 + k, 8'h11 * k + 1);
      send(1'b0, 40 + k, 0);
    end
    for (int k = 0; k < 6; k++) send(1'b0, 40 + k, 0);
    send(1'b0, 255, 0);
    repeat (3) @(negedge clk);
    send(1'b1, 0, 8'hFF);
    send(1'b0, 0, 0);
    repeat (8) @(negedge clk);
    finish_run();
  end

endmodule